// File: doc/BRIEF.md
# General-Purpose Register File with Hardwired Zero

This block is the operand store of a small load/store processor core. It keeps thirty-two 32-bit registers. Two read ports are combinational, and one write port is clocked. A three-operand instruction can therefore fetch both sources and retire its destination in the same cycle.

Index 0 is not storage. It always reads as zero, and any write aimed at it is dropped. Software can use it as a constant source for moves and compares.

A read of the register being written in the same cycle returns the value held before the edge, because there is no internal bypass. Any forwarding belongs to the pipeline around the block. An active-low asynchronous reset clears every register.

Top module: `gpr_file`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every register reads as zero until it is written.
- R2: On a rising edge of `clk_i` with `wr_en_i` high and `wr_addr_i` nonzero, `wr_data_i` is stored in the addressed register, and it reads back on either port from then on.
- R3: On an edge with `wr_en_i` low, no register changes, whatever `wr_addr_i` and `wr_data_i` hold.
- R4: A read port addressed with index 0 returns 32'h0000_0000 at all times.
- R5: A write with `wr_addr_i` equal to 0 changes no register, and index 0 still reads zero afterwards.
- R6: The two read ports are independent. Each returns the register selected by its own 5-bit address, and both may select the same register.
- R7: A read that selects the register being written in the same cycle returns the old value before the edge and the new value after it.
- R8: A write changes only the addressed register and leaves the other 30 writable registers intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes land on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all registers |
| rd_a_addr_i | input | 5 | Index for read port A |
| rd_a_data_o | output | 32 | Register value on port A (combinational) |
| rd_b_addr_i | input | 5 | Index for read port B |
| rd_b_data_o | output | 32 | Register value on port B (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Destination index |
| wr_data_i | input | 32 | Data to store |

## Verification
The case that is hardest to reach from the ports is a read and a write meeting on the same index in one cycle. The bench handles it by setting both read addresses to the write address while the write is pending. It samples the read data just before the rising edge and again just after it. To show that a discarded write to index 0 has no effect, the bench follows it with a full sweep of every register on both ports and compares each one against its reference array. A run of random writes, with the enable toggled, then mixes these cases together.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;
  localparam int unsigned GPR_COUNT = 32;
  localparam int unsigned GPR_WIDTH = 32;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NumRegs   = 32,
  parameter int unsigned AddrWidth = $clog2(NumRegs)
) (
  input  logic                 en_i,
  input  logic [AddrWidth-1:0] addr_i,
  output logic [NumRegs-1:0]   strobe_o
);
  for (genvar i = 0; i < NumRegs; i++) begin : g_dec
    if (i == 0) begin : g_zero
      // index 0 has no storage, so no strobe
      assign strobe_o[i] = 1'b0;
    end else begin : g_live
      assign strobe_o[i] = en_i && (addr_i == AddrWidth'(i));
    end
  end
endmodule

// File: rtl/gpr_word.sv
module gpr_word #(
  parameter int unsigned DataWidth = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [DataWidth-1:0] d_i,
  output logic [DataWidth-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int unsigned NumRegs   = 32,
  parameter int unsigned DataWidth = 32,
  parameter int unsigned AddrWidth = $clog2(NumRegs)
) (
  input  logic [NumRegs-1:0][DataWidth-1:0] regs_i,
  input  logic [AddrWidth-1:0]              addr_i,
  output logic [DataWidth-1:0]              data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NumRegs; i++) begin
      if (addr_i == AddrWidth'(i)) data_o = regs_i[i];
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_file_pkg::*;
#(
  parameter int unsigned NumRegs   = GPR_COUNT,
  parameter int unsigned DataWidth = GPR_WIDTH,
  parameter int unsigned AddrWidth = $clog2(NumRegs)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AddrWidth-1:0] rd_a_addr_i,
  output logic [DataWidth-1:0] rd_a_data_o,
  input  logic [AddrWidth-1:0] rd_b_addr_i,
  output logic [DataWidth-1:0] rd_b_data_o,
  input  logic                 wr_en_i,
  input  logic [AddrWidth-1:0] wr_addr_i,
  input  logic [DataWidth-1:0] wr_data_i
);
  logic [NumRegs-1:0]                wr_strobe;
  logic [NumRegs-1:0][DataWidth-1:0] regs;

  gpr_wr_decode #(.NumRegs(NumRegs), .AddrWidth(AddrWidth)) u_dec (
    .en_i     (wr_en_i),
    .addr_i   (wr_addr_i),
    .strobe_o (wr_strobe)
  );

  for (genvar i = 0; i < NumRegs; i++) begin : g_reg
    if (i == 0) begin : g_hardzero
      assign regs[i] = '0;
    end else begin : g_store
      gpr_word #(.DataWidth(DataWidth)) u_word (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (wr_strobe[i]),
        .d_i    (wr_data_i),
        .q_o    (regs[i])
      );
    end
  end

  // Reads see pre-edge contents; no write bypass.
  gpr_rd_port #(.NumRegs(NumRegs), .DataWidth(DataWidth), .AddrWidth(AddrWidth)) u_rd_a (
    .regs_i (regs),
    .addr_i (rd_a_addr_i),
    .data_o (rd_a_data_o)
  );

  gpr_rd_port #(.NumRegs(NumRegs), .DataWidth(DataWidth), .AddrWidth(AddrWidth)) u_rd_b (
    .regs_i (regs),
    .addr_i (rd_b_addr_i),
    .data_o (rd_b_data_o)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned DataWidth = 32,
  parameter int unsigned AddrWidth = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AddrWidth-1:0] rd_a_addr_i,
  input logic [DataWidth-1:0] rd_a_data_o,
  input logic [AddrWidth-1:0] rd_b_addr_i,
  input logic [DataWidth-1:0] rd_b_data_o,
  input logic                 wr_en_i,
  input logic [AddrWidth-1:0] wr_addr_i,
  input logic [DataWidth-1:0] wr_data_i
);
  AST_ZERO_READ_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0)); // R4
  AST_ZERO_READ_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == '0) |-> (rd_b_data_o == '0)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=>
      ((rd_a_addr_i == $past(wr_addr_i)) -> (rd_a_data_o == $past(wr_data_i)))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(rd_a_addr_i) -> $stable(rd_a_data_o))); // R3
  AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0) |=> ($stable(rd_b_addr_i) -> $stable(rd_b_data_o))); // R5
  AST_PORTS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == rd_b_addr_i) |-> (rd_a_data_o == rd_b_data_o)); // R6
endmodule

bind gpr_file gpr_file_chk #(.DataWidth(DataWidth), .AddrWidth(AddrWidth)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_addr_i (rd_a_addr_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_addr_i (rd_b_addr_i),
  .rd_b_data_o (rd_b_data_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/gpr_file_tb.sv
`timescale 1ns/1ps
module gpr_file_tb;
  localparam int N = 32;
  localparam int W = 32;
  localparam int A = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [A-1:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [W-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic         wr_en = 1'b0;

  logic [W-1:0] ref_mem [N];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  gpr_file u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rd_a_addr_i (rd_a_addr),
    .rd_a_data_o (rd_a_data),
    .rd_b_addr_i (rd_b_addr),
    .rd_b_data_o (rd_b_data),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // one write, inputs changed on the falling edge
  task automatic do_write(input logic en, input logic [A-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (en && a != 0) ref_mem[a] = d;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) begin
      rd_a_addr = A'(i); rd_b_addr = A'(N - 1 - i);
      #1;
      check(req, rd_a_data, ref_mem[i]);
      check(req, rd_b_data, ref_mem[N - 1 - i]);
    end
  endtask

  task automatic t_reset;
    do_write(1'b1, 5'd7, 32'hdead_beef);
    do_write(1'b1, 5'd31, 32'h1234_5678);
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < N; i++) ref_mem[i] = '0;
    #1;
    sweep("R1 during reset");
    @(negedge clk);
    rst_ni = 1'b1;
    sweep("R1 after reset");
  endtask

  task automatic t_write_read;
    do_write(1'b1, 5'd1, 32'h0000_0001);
    do_write(1'b1, 5'd2, 32'hffff_ffff);
    do_write(1'b1, 5'd31, 32'ha5a5_5a5a);
    do_write(1'b1, 5'd2, 32'h8000_0000);
    rd_a_addr = 5'd2; #1; check("R2 overwrite", rd_a_data, 32'h8000_0000);
    rd_b_addr = 5'd31; #1; check("R2 port B", rd_b_data, 32'ha5a5_5a5a);
    sweep("R8 others intact");
  endtask

  task automatic t_enable_low;
    do_write(1'b0, 5'd1, 32'hcafe_f00d);
    do_write(1'b0, 5'd9, 32'hcafe_f00d);
    rd_a_addr = 5'd1; #1; check("R3 disabled write", rd_a_data, 32'h0000_0001);
    rd_b_addr = 5'd9; #1; check("R3 disabled write", rd_b_data, ref_mem[9]);
  endtask

  task automatic t_zero_write;
    do_write(1'b1, 5'd0, 32'hffff_ffff);
    rd_a_addr = 5'd0; rd_b_addr = 5'd0; #1;
    check("R4 zero read A", rd_a_data, '0);
    check("R5 zero write dropped", rd_b_data, '0);
    sweep("R5 nothing else changed");
  endtask

  task automatic t_dual_read;
    rd_a_addr = 5'd31; rd_b_addr = 5'd31; #1;
    check("R6 same index A", rd_a_data, ref_mem[31]);
    check("R6 same index B", rd_b_data, ref_mem[31]);
    rd_a_addr = 5'd1; rd_b_addr = 5'd2; #1;
    check("R6 split A", rd_a_data, ref_mem[1]);
    check("R6 split B", rd_b_data, ref_mem[2]);
  endtask

  task automatic t_same_cycle;
    logic [W-1:0] old_v;
    old_v = ref_mem[5];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h0bad_c0de;
    rd_a_addr = 5'd5; rd_b_addr = 5'd5;
    #1;
    check("R7 before edge A", rd_a_data, old_v);
    check("R7 before edge B", rd_b_data, old_v);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    ref_mem[5] = 32'h0bad_c0de;
    check("R7 after edge A", rd_a_data, 32'h0bad_c0de);
    check("R7 after edge B", rd_b_data, 32'h0bad_c0de);
  endtask

  task automatic t_random;
    for (int k = 0; k < 200; k++) begin
      logic en;
      logic [A-1:0] a;
      en = ($urandom % 4) != 0;
      a  = A'($urandom % N);
      do_write(en, a, $urandom);
    end
    sweep("R2 R3 R5 R8 random");
  endtask

  initial begin
    for (int i = 0; i < N; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_write_read();
    t_enable_low();
    t_zero_write();
    t_dual_read();
    t_same_cycle();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule